// File: doc/BRIEF.md
# Self-Synchronizing Serial Scrambler with NRZI Line Coding

This block sits on the serial side of a high-rate video link. Its transmit half takes the NRZ bit stream that leaves the word serializer. It randomizes that stream with a self-synchronizing scrambler built on the polynomial x^9 + x^4 + 1, so that long runs of equal bits are broken up. It then applies NRZI coding, where every one becomes a level change on the line. A clock regenerator downstream works on this scrambled NRZI signal.

The receive half runs the same steps in the opposite order. It first turns NRZI back into NRZ by comparing each line bit with the one before it. It then removes the scrambling, using the history of the bits it has received. The two halves share no seed and no framing. A receiver that starts in any state, or that sees the line with its polarity inverted, produces correct data once enough bits have passed through it. Each half advances only on the cycles where its own bit-enable is high.

Top module: `sdi_line_coder`

## Requirements
- R1: After synchronous reset, `tx_line` and `rx_bit` are 0, and the scrambler history, descrambler history, NRZI line level and last received line bit are all cleared to 0.
- R2: On a cycle with `tx_en` high, the scrambled bit is s = tx_bit ^ h[3] ^ h[8]. Here h[k] is the scrambled bit produced k+1 enabled bits earlier, and it is 0 for positions not yet filled since reset.
- R3: `tx_line` toggles at the clock edge of a cycle with `tx_en` high whose scrambled bit is 1. It holds its level when that bit is 0. The new level is visible in the cycle after the enabled cycle.
- R4: While `tx_en` is low, `tx_line` keeps its value and the transmit state does not advance, whatever `tx_bit` carries.
- R5: On a cycle with `rx_en` high, the block forms n = rx_line ^ p, where p is the `rx_line` value of the previous enabled cycle (0 after reset). It then forms d = n ^ g[3] ^ g[8], where g[k] is the n value k+1 enabled cycles earlier. `rx_bit` presents d in the following cycle.
- R6: While `rx_en` is low, `rx_bit` keeps its value and the receive state does not advance, whatever `rx_line` carries.
- R7: With the transmit line fed back to the receive input, each received bit from the 11th enabled receive bit onward equals the transmitted data bit. This holds for any prior receive state, for either line polarity, and for any data, including long runs of zeros or ones and every 9-bit pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_en | input | 1 | Transmit bit-enable |
| tx_bit | input | 1 | NRZ data bit to send |
| tx_line | output | 1 | Scrambled NRZI line level |
| rx_en | input | 1 | Receive bit-enable |
| rx_line | input | 1 | NRZI line level received |
| rx_bit | output | 1 | Recovered NRZ data bit |

## Verification
The properties assume that each enable is a clean 0 or 1 sampled on the rising edge. They also assume that the transmit NRZI toggle follows the scrambled bit, whatever the data pattern. The bench changes every input only at the falling edge. It drives the receive side either with random line bits, to push the descrambler into an unknown state, or with the transmit line fed back with or without inversion. Idle cycles with random data on the disabled inputs are placed between bits, so the hold behaviour is exercised on both halves. Stimulus includes long constant runs and a sweep of all 512 nine-bit patterns.

// File: rtl/sdi_line_pkg.sv
package sdi_line_pkg;

    // one serial bit together with its enable
    typedef struct packed {
        logic valid;
        logic data;
    } beat_t;

    // which side of the self-synchronizing pair an instance implements
    typedef enum logic {
        SS_SCRAMBLE   = 1'b0,
        SS_DESCRAMBLE = 1'b1
    } ss_dir_e;

    // default shift history length and inner tap of x^9 + x^4 + 1
    localparam int unsigned POLY_LEN = 9;
    localparam int unsigned POLY_TAP = 4;

    function automatic beat_t mk_beat(input logic v, input logic d);
        beat_t b;
        b.valid = v;
        b.data  = d;
        return b;
    endfunction

endpackage

// File: rtl/sdi_self_sync.sv
module sdi_self_sync
    import sdi_line_pkg::*;
#(
    parameter int unsigned LEN = POLY_LEN,
    parameter int unsigned TAP = POLY_TAP,
    parameter ss_dir_e     DIR = SS_SCRAMBLE
) (
    input  logic  clk,
    input  logic  rst,
    input  beat_t in_beat,
    output beat_t out_beat
);

    logic [LEN-1:0] hist_q;
    logic           mix;
    logic           feed;

    // two-tap feedforward/feedback term
    assign mix      = hist_q[TAP-1] ^ hist_q[LEN-1];
    assign out_beat = mk_beat(in_beat.valid, in_beat.data ^ mix);

    // scrambler remembers what it sends, descrambler remembers what it hears
    generate
        if (DIR == SS_SCRAMBLE) begin : g_fwd
            assign feed = out_beat.data;
        end else begin : g_bwd
            assign feed = in_beat.data;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else if (in_beat.valid) begin
            hist_q <= {hist_q[LEN-2:0], feed};
        end
    end

endmodule

// File: rtl/sdi_nrzi_enc.sv
module sdi_nrzi_enc
    import sdi_line_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  beat_t in_beat,
    output logic  line_o
);

    // a one flips the level, a zero leaves it
    always_ff @(posedge clk) begin
        if (rst) begin
            line_o <= 1'b0;
        end else if (in_beat.valid) begin
            line_o <= line_o ^ in_beat.data;
        end
    end

endmodule

// File: rtl/sdi_nrzi_dec.sv
module sdi_nrzi_dec
    import sdi_line_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  beat_t in_beat,
    output beat_t out_beat
);

    logic prev_q;

    // a change of level between enabled samples is a one
    assign out_beat = mk_beat(in_beat.valid, in_beat.data ^ prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
        end else if (in_beat.valid) begin
            prev_q <= in_beat.data;
        end
    end

endmodule

// File: rtl/sdi_line_coder.sv
module sdi_line_coder
    import sdi_line_pkg::*;
#(
    parameter int unsigned LEN = POLY_LEN,
    parameter int unsigned TAP = POLY_TAP
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_en,
    input  logic tx_bit,
    output logic tx_line,
    input  logic rx_en,
    input  logic rx_line,
    output logic rx_bit
);

    beat_t tx_raw_b;
    beat_t tx_scr_b;
    beat_t rx_raw_b;
    beat_t rx_nrz_b;
    beat_t rx_out_b;
    logic  tx_scr;

    // ---------------- transmit: scramble, then NRZI ----------------
    assign tx_raw_b = mk_beat(tx_en, tx_bit);

    sdi_self_sync #(
        .LEN (LEN),
        .TAP (TAP),
        .DIR (SS_SCRAMBLE)
    ) u_scr (
        .clk      (clk),
        .rst      (rst),
        .in_beat  (tx_raw_b),
        .out_beat (tx_scr_b)
    );

    assign tx_scr = tx_scr_b.data;

    sdi_nrzi_enc u_enc (
        .clk     (clk),
        .rst     (rst),
        .in_beat (tx_scr_b),
        .line_o  (tx_line)
    );

    // ---------------- receive: NRZI decode, then descramble ----------------
    assign rx_raw_b = mk_beat(rx_en, rx_line);

    sdi_nrzi_dec u_dec (
        .clk      (clk),
        .rst      (rst),
        .in_beat  (rx_raw_b),
        .out_beat (rx_nrz_b)
    );

    sdi_self_sync #(
        .LEN (LEN),
        .TAP (TAP),
        .DIR (SS_DESCRAMBLE)
    ) u_dscr (
        .clk      (clk),
        .rst      (rst),
        .in_beat  (rx_nrz_b),
        .out_beat (rx_out_b)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_bit <= 1'b0;
        end else if (rx_out_b.valid) begin
            rx_bit <= rx_out_b.data;
        end
    end

endmodule

// File: rtl/sdi_line_coder_chk.sv
module sdi_line_coder_chk (
    input logic clk,
    input logic rst,
    input logic tx_en,
    input logic tx_scr,
    input logic tx_line,
    input logic rx_en,
    input logic rx_bit
);

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (tx_line == 1'b0 && rx_bit == 1'b0)); // R1

    AST_LINE_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (tx_en && tx_scr) |=> (tx_line != $past(tx_line))); // R3

    AST_LINE_STEADY: assert property (@(posedge clk) disable iff (rst)
        (tx_en && !tx_scr) |=> $stable(tx_line)); // R3

    AST_TX_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> $stable(tx_line)); // R4

    AST_RX_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> $stable(rx_bit)); // R6

endmodule

bind sdi_line_coder sdi_line_coder_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .tx_en   (tx_en),
    .tx_scr  (tx_scr),
    .tx_line (tx_line),
    .rx_en   (rx_en),
    .rx_bit  (rx_bit)
);

// File: tb/test_sdi_line_coder.sv
module test_sdi_line_coder;

    localparam int LEN = 9;
    localparam int TAP = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_en = 1'b0, tx_bit = 1'b0, rx_en = 1'b0, rx_line = 1'b0;
    logic tx_line, rx_bit;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // bench-side models from the requirement formulas
    logic [LEN-1:0] m_txh;
    logic           m_lvl;
    logic [LEN-1:0] m_rxg;
    logic           m_prev;
    logic           inv;
    int             n_sync;

    always #10 clk = ~clk;  // 50 MHz

    sdi_line_coder i_sdi_line_coder (
        .clk     (clk),
        .rst     (rst),
        .tx_en   (tx_en),
        .tx_bit  (tx_bit),
        .tx_line (tx_line),
        .rx_en   (rx_en),
        .rx_line (rx_line),
        .rx_bit  (rx_bit)
    );

    task automatic chk(input logic act, input logic exp, input string req);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b (vector %0d)", req, act, exp, n_vec);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // one enabled receive bit; checks the R5 model and, once synced, R7
    task automatic rx_step(input logic ln, input logic sent, input bit loop);
        logic n, d;
        rx_en   = 1'b1;
        rx_line = ln;
        n       = ln ^ m_prev;
        m_prev  = ln;
        d       = n ^ m_rxg[TAP-1] ^ m_rxg[LEN-1];
        m_rxg   = {m_rxg[LEN-2:0], n};
        @(negedge clk);
        rx_en = 1'b0;
        chk(rx_bit, d, "R5");
        if (loop) begin
            n_sync++;
            if (n_sync > LEN + 1) chk(rx_bit, sent, "R7");
        end
    endtask

    // transmit one bit (R2/R3 model), then feed the line back
    task automatic loop_bit(input logic b);
        logic s;
        @(negedge clk);
        tx_en  = 1'b1;
        tx_bit = b;
        s      = b ^ m_txh[TAP-1] ^ m_txh[LEN-1];  // R2
        m_txh  = {m_txh[LEN-2:0], s};
        m_lvl  = m_lvl ^ s;
        @(negedge clk);
        tx_en = 1'b0;
        chk(tx_line, m_lvl, "R3");
        rx_step(tx_line ^ inv, b, 1'b1);
    endtask

    // both enables low with random data on the ignored inputs
    task automatic idle_cycle();
        logic hold_tx, hold_rx;
        hold_tx = tx_line;
        hold_rx = rx_bit;
        tx_en   = 1'b0;
        rx_en   = 1'b0;
        tx_bit  = 1'($urandom);
        rx_line = 1'($urandom);
        @(negedge clk);
        chk(tx_line, hold_tx, "R4");
        chk(rx_bit, hold_rx, "R6");
    endtask

    // scramble the receive state with random line bits
    task automatic rx_garbage(input int count);
        for (int i = 0; i < count; i++) begin
            logic hold_tx;
            hold_tx = tx_line;
            @(negedge clk);
            tx_bit = 1'($urandom);
            rx_step(1'($urandom), 1'b0, 1'b0);
            chk(tx_line, hold_tx, "R4");
        end
        n_sync = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

    initial begin
        m_txh  = '0;
        m_lvl  = 1'b0;
        m_rxg  = '0;
        m_prev = 1'b0;
        inv    = 1'b0;
        n_sync = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(tx_line, 1'b0, "R1");
        chk(rx_bit, 1'b0, "R1");

        // straight loopback from reset state
        for (int i = 0; i < 300; i++) begin
            loop_bit(1'($urandom));
            if (i % 7 == 3) idle_cycle();
        end

        // unknown receive state, matched polarity, long runs
        rx_garbage(37);
        for (int i = 0; i < 200; i++) loop_bit(1'b0);
        for (int i = 0; i < 200; i++) loop_bit(1'b1);
        for (int i = 0; i < 400; i++) begin
            loop_bit(1'($urandom));
            if (i % 11 == 5) idle_cycle();
        end

        // every 9-bit pattern in sequence
        for (int v = 0; v < 512; v++) begin
            for (int k = LEN - 1; k >= 0; k--) loop_bit(v[k]);
        end

        // inverted line after random receive state
        inv = 1'b1;
        rx_garbage(23);
        for (int i = 0; i < 150; i++) loop_bit(1'b0);
        for (int i = 0; i < 500; i++) begin
            loop_bit(1'($urandom));
            if (i % 5 == 2) idle_cycle();
        end

        summary();
    end

endmodule